// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block holds a small set of hardware event counters for a processor core. Each counter watches one countable condition picked from a vector of single-cycle event strobes. On every clock edge it adds one when that condition's strobe is high and the global run bit is set. Condition code 0 is wired to "never", so giving a counter code 0 is the only way to halt that counter alone.

Software reaches the counters through a narrow register port. It writes a counter number to the selector register. The condition, count-low and count-high registers then act on that counter. A snapshot command copies the selected counter into a pair of holding registers, so a value wider than 32 bits can be read as two halves without a carry slipping in between the two reads.

Two read-only descriptors report the number of counters, the counter width code and the number of conditions. A two-state machine runs the snapshot sequence. `SN_IDLE` moves to `SN_LATCH` when a control write sets the snapshot bit. `SN_LATCH` copies the selected counter at the end of its cycle. It then returns to `SN_IDLE`, or stays in `SN_LATCH` if another snapshot request arrives in that cycle.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter, every condition code, the selector, the control bits and the snapshot registers read as zero.
- R2: Register addresses are 0 selector (8 bits, reads back as written), 1 control, 2 condition code, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 counter descriptor and 8 condition descriptor. Other addresses read zero. Registers 2 to 4 act on the counter named by the selector.
- R3: A counter with a nonzero condition code c adds exactly one on each clock edge where the run bit is 1 and cond_strobe[c] is 1. Other strobe bits have no effect on it.
- R4: Condition code 0 never counts, whatever the strobes carry, including cond_strobe[0].
- R5: Control bit 0 is the global run bit. While it is 0, no counter changes except by a software write.
- R6: Control bits 31:16 hold the last value written to them and read back unchanged. Control bits 15:2 read as zero.
- R7: Writing control with bit 1 set starts a snapshot. Bit 1 reads 1 during the cycle after the write and 0 after that. On the edge that ends that cycle, the selected counter is copied into snapshot low (bits 31:0) and snapshot high (the bits above 31).
- R8: In count high and snapshot high, bits at or above the counter width minus 32 read as zero.
- R9: Count low and count high are writable. A software write to a counter takes priority over an increment in the same cycle, and that increment is lost.
- R10: Counters wrap modulo 2^(32+16*SIZE_SEL) and do not saturate.
- R11: With a selector at or beyond NUM_CTR, writes to the condition and count registers change nothing, reads of them return zero, and a snapshot captures zero.
- R12: The counter descriptor has bit 0 set to 1, bits 15:8 equal to NUM_CTR and bits 17:16 equal to SIZE_SEL. All other bits are 0.
- R13: The condition descriptor has bit 0 set to 1 and bits 15:8 equal to NUM_COND. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cond_strobe | input | NUM_COND | Event strobes, bit c is condition c |

## Verification
Two pairs of functions can land on the same clock edge: a software count write with an increment, and a snapshot copy with an increment. The bench provokes the first by driving a count-low write in the same cycle that the counted strobe is high. It expects the written value with no extra increment. It provokes the second by holding the strobe high across the snapshot write and the latch cycle after it. It expects the snapshot to hold the count as it stood after the first edge, and the live counter to be one higher.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    typedef enum logic [3:0] {
        A_SEL        = 4'd0,
        A_CTRL       = 4'd1,
        A_COND       = 4'd2,
        A_CNT_LO     = 4'd3,
        A_CNT_HI     = 4'd4,
        A_SNAP_LO    = 4'd5,
        A_SNAP_HI    = 4'd6,
        A_CTR_DESC   = 4'd7,
        A_COND_DESC  = 4'd8
    } reg_addr_e;

    typedef enum logic {
        SN_IDLE  = 1'b0,
        SN_LATCH = 1'b1
    } snap_state_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SNAP_BIT = 1;

endpackage

// File: rtl/ecb_snap_ctrl.sv
module ecb_snap_ctrl
    import ecb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snap_req,
    output logic snap_busy,
    output logic latch_en
);

    snap_state_e state_q;
    snap_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SN_IDLE:  state_d = snap_req ? SN_LATCH : SN_IDLE;
            SN_LATCH: state_d = snap_req ? SN_LATCH : SN_IDLE;
            default:  state_d = SN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        snap_busy = 1'b0;
        latch_en  = 1'b0;
        unique case (state_q)
            SN_IDLE: begin
                snap_busy = 1'b0;
                latch_en  = 1'b0;
            end
            SN_LATCH: begin
                snap_busy = 1'b1;
                latch_en  = 1'b1;
            end
            default: begin
                snap_busy = 1'b0;
                latch_en  = 1'b0;
            end
        endcase
    end

    // R7: a request is visible as busy in the following cycle
    assert_snap_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap_busy);

    // R7: the busy flag lasts a single cycle unless re-requested
    assert_snap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && !snap_req) |=> !snap_busy);

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int CTR_W    = 48,
    parameter int NUM_COND = 8,
    parameter int CC_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [NUM_COND-1:0] strobes,
    input  logic                cond_we,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [31:0]         wdata,
    output logic [CC_W-1:0]     cond_q,
    output logic [CTR_W-1:0]    count_q
);

    localparam int HI_W = CTR_W - 32;
    localparam logic [CTR_W-1:0] STEP = CTR_W'(1);

    logic hit;
    logic sw_write;

    assign sw_write = lo_we | hi_we;

    // condition lookup; code 0 never matches
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_COND; k++) begin
            if ((k != 0) && (cond_q == CC_W'(k)) && strobes[k]) begin
                hit = 1'b1;
            end
        end
        hit = hit & run_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (cond_we) begin
            cond_q <= wdata[CC_W-1:0];
        end
    end

    // software write wins over the increment of the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (sw_write) begin
            if (lo_we) begin
                count_q[31:0] <= wdata;
            end
            if (hi_we) begin
                count_q[CTR_W-1:32] <= wdata[HI_W-1:0];
            end
        end else if (hit) begin
            count_q <= count_q + STEP;
        end
    end

    // R3: without software writes a counter moves by zero or one per edge
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_write |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + STEP));

    // R4: code 0 holds the counter still
    assert_never_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_q == '0 && !sw_write) |=> $stable(count_q));

    // R5: global run bit low freezes the counter
    assert_run_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !sw_write) |=> $stable(count_q));

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int SIZE_SEL = 1,
    parameter int NUM_COND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_COND-1:0] cond_strobe
);

    localparam int CTR_W = 32 + 16 * SIZE_SEL;
    localparam int CC_W  = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
    localparam int SEL_W = 8;

    logic [SEL_W-1:0] sel_q;
    logic             run_q;
    logic [15:0]      ctrl_hi_q;
    logic [CTR_W-1:0] snap_q;

    logic             sel_ok;
    logic             wr_sel, wr_ctrl, wr_cond, wr_lo, wr_hi;
    logic             snap_req, snap_busy, latch_en;

    logic [CC_W-1:0]  cond_arr [NUM_CTR];
    logic [CTR_W-1:0] cnt_arr  [NUM_CTR];
    logic [CC_W-1:0]  sel_cond;
    logic [CTR_W-1:0] sel_cnt;
    logic [63:0]      cnt_wide;
    logic [63:0]      snap_wide;

    assign sel_ok   = (sel_q < SEL_W'(NUM_CTR));
    assign wr_sel   = reg_wr && (reg_addr == A_SEL);
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_cond  = reg_wr && (reg_addr == A_COND)   && sel_ok;
    assign wr_lo    = reg_wr && (reg_addr == A_CNT_LO) && sel_ok;
    assign wr_hi    = reg_wr && (reg_addr == A_CNT_HI) && sel_ok;
    assign snap_req = wr_ctrl && reg_wdata[CTRL_SNAP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            run_q     <= 1'b0;
            ctrl_hi_q <= '0;
        end else begin
            if (wr_sel) begin
                sel_q <= reg_wdata[SEL_W-1:0];
            end
            if (wr_ctrl) begin
                run_q     <= reg_wdata[CTRL_RUN_BIT];
                ctrl_hi_q <= reg_wdata[31:16];
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
            logic hit_sel;
            assign hit_sel = (sel_q == SEL_W'(gi));

            ecb_counter #(
                .CTR_W    (CTR_W),
                .NUM_COND (NUM_COND),
                .CC_W     (CC_W)
            ) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_en  (run_q),
                .strobes (cond_strobe),
                .cond_we (wr_cond && hit_sel),
                .lo_we   (wr_lo && hit_sel),
                .hi_we   (wr_hi && hit_sel),
                .wdata   (reg_wdata),
                .cond_q  (cond_arr[gi]),
                .count_q (cnt_arr[gi])
            );
        end
    endgenerate

    // selected counter view; out-of-range selector yields zero
    always_comb begin
        sel_cond = '0;
        sel_cnt  = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (sel_q == SEL_W'(i)) begin
                sel_cond = cond_arr[i];
                sel_cnt  = cnt_arr[i];
            end
        end
    end

    ecb_snap_ctrl u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_req  (snap_req),
        .snap_busy (snap_busy),
        .latch_en  (latch_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (latch_en) begin
            snap_q <= sel_cnt;
        end
    end

    assign cnt_wide  = 64'(sel_cnt);
    assign snap_wide = 64'(snap_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SEL:       reg_rdata = 32'(sel_q);
            A_CTRL:      reg_rdata = {ctrl_hi_q, 14'b0, snap_busy, run_q};
            A_COND:      reg_rdata = 32'(sel_cond);
            A_CNT_LO:    reg_rdata = cnt_wide[31:0];
            A_CNT_HI:    reg_rdata = cnt_wide[63:32];
            A_SNAP_LO:   reg_rdata = snap_wide[31:0];
            A_SNAP_HI:   reg_rdata = snap_wide[63:32];
            A_CTR_DESC:  reg_rdata = {14'b0, 2'(SIZE_SEL), 8'(NUM_CTR), 7'b0, 1'b1};
            A_COND_DESC: reg_rdata = {16'b0, 8'(NUM_COND), 7'b0, 1'b1};
            default:     reg_rdata = '0;
        endcase
    end

    // R11: an unimplemented selector reads zero through the per-counter registers
    assert_oob_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && (reg_addr == A_COND || reg_addr == A_CNT_LO || reg_addr == A_CNT_HI))
        |-> (reg_rdata == 32'd0));

    // R6: upper control bits move only on a control write
    assert_ctrl_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_hi_q));

    // R7: the snapshot holds between latch cycles
    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(snap_q));

endmodule

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;

    localparam int NCTR  = 4;
    localparam int SSEL  = 1;
    localparam int NCOND = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [NCOND-1:0] cond_strobe = '0;

    int total = 0;
    int bad = 0;

    evt_counter_bank #(.NUM_CTR(NCTR), .SIZE_SEL(SSEL), .NUM_COND(NCOND)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_strobe(cond_strobe)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run(input logic [NCOND-1:0] pat, input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            cond_strobe = pat;
        end
        @(negedge clk);
        cond_strobe = '0;
    endtask

    task automatic rd_count(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(4'd3, lo);
        rd(4'd4, hi);
        v = {hi, lo};
    endtask

    task automatic rd_snap(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(4'd5, lo);
        rd(4'd6, hi);
        v = {hi, lo};
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd1, d); check("R1 ctrl", d, 0);
        rd(4'd0, d); check("R1 sel", d, 0);
        rd(4'd2, d); check("R1 cond", d, 0);
        rd_count(v); check("R1 count", v, 0);
        rd_snap(v);  check("R1 snap", v, 0);
        rd(4'd12, d); check("R2 unused addr", d, 0);

        // R12 R13 descriptors
        rd(4'd7, d); check("R12 ctr desc", d, (SSEL << 16) | (NCTR << 8) | 1);
        rd(4'd8, d); check("R13 cond desc", d, (NCOND << 8) | 1);

        // R6 upper control bits
        wr(4'd1, 32'hABCD_FFFC);
        rd(4'd1, d); check("R6 upper kept, 15:2 zero", d, 32'hABCD_0000);
        wr(4'd1, 32'hABCD_0001);
        rd(4'd1, d); check("R6 run set upper kept", d, 32'hABCD_0001);

        // R3 sweep: every counter against every nonzero condition
        for (int i = 0; i < NCTR; i++) begin
            for (int c = 1; c < NCOND; c++) begin
                int n;
                logic [NCOND-1:0] own;
                n = ((i * 7 + c) % 9) + 2;
                own = NCOND'(1) << c;
                wr(4'd0, 32'(i));
                wr(4'd2, 32'(c));
                wr(4'd3, 0);
                wr(4'd4, 0);
                rd(4'd2, d); check("R2 cond readback", d, 32'(c));
                run(own, n);
                run(~own, 3);
                rd_count(v); check("R3 count matches pulses", v, 64'(n));
            end
        end

        // R4 code 0 never counts, strobe bit 0 included
        wr(4'd0, 0); wr(4'd2, 0); wr(4'd3, 0); wr(4'd4, 0);
        run('1, 5);
        rd_count(v); check("R4 code 0 frozen", v, 0);

        // R5 run bit low
        wr(4'd0, 1); wr(4'd3, 0); wr(4'd4, 0);
        wr(4'd1, 32'hABCD_0000);
        run('1, 6);
        rd_count(v); check("R5 halted while run low", v, 0);
        wr(4'd1, 32'hABCD_0001);
        run('1, 2);
        rd_count(v); check("R5 resumes", v, 2);

        // R10 wrap and R8 high-bit width
        wr(4'd0, 2); wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, d); check("R8 count high width", d, 32'h0000_FFFF);
        run(8'h80, 1);
        rd_count(v); check("R10 wrap to zero", v, 0);
        run(8'h80, 1);
        rd_count(v); check("R10 counts after wrap", v, 1);

        // R7 snapshot sequence
        wr(4'd0, 3); wr(4'd3, 0); wr(4'd4, 0);
        run(8'h80, 10);
        wr(4'd1, 32'hABCD_0003);
        #1;
        check("R7 snap bit set one cycle", reg_rdata[1], 1);
        rd(4'd1, d); check("R7 snap bit cleared", d, 32'hABCD_0001);
        rd_snap(v); check("R7 snapshot value", v, 10);
        run(8'h80, 4);
        rd_snap(v); check("R7 snapshot held", v, 10);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd1, 32'hABCD_0003);
        rd(4'd6, d); check("R8 snapshot high width", d, 32'h0000_FFFF);

        // R9 write versus increment in one cycle
        wr(4'd0, 0); wr(4'd2, 5); wr(4'd4, 0); wr(4'd3, 100);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 7; cond_strobe = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0; cond_strobe = '0;
        rd_count(v); check("R9 write wins", v, 7);

        // R7 snapshot versus increment in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'hABCD_0003; cond_strobe = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        cond_strobe = '0;
        rd_snap(v);  check("R7 snap during count", v, 8);
        rd_count(v); check("R7 live count after snap", v, 9);

        // R11 out-of-range selector
        wr(4'd0, NCTR);
        rd(4'd0, d); check("R2 selector readback", d, NCTR);
        wr(4'd2, 3); wr(4'd3, 55);
        rd(4'd2, d); check("R11 cond reads zero", d, 0);
        rd_count(v); check("R11 count reads zero", v, 0);
        wr(4'd1, 32'hABCD_0003);
        rd_snap(v); check("R11 snapshot zero", v, 0);
        wr(4'd0, 0);
        rd(4'd2, d); check("R11 cond untouched", d, 5);
        rd_count(v); check("R11 count untouched", v, 9);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule